// File: doc/BRIEF.md
# SDRAM burst interrupt scheduler

This block sits inside an SDRAM controller. It follows the one data burst that is running on the shared data bus of a four-bank SDRAM, and it decides what happens when a new READ or WRITE to bank m cuts short a burst that bank n has not finished. For each clock it reports which bank owns the data bus and in which direction. It drives the data mask (DQM) early enough to keep a write from colliding with read data. It also pulses a per-bank strobe in the cycle in which a pending auto-precharge of a bank begins. Interrupted auto-precharge banks are handled concurrently: the precharge of bank n is started by the command to bank m.

Commands arrive two clocks ahead of the edge at which the device registers them. This gives the block time to raise DQM up to two clocks before an interrupting WRITE. CAS latency, burst length and write recovery are static configuration inputs. Timing terms used below: a command sampled at rising edge A is *registered* at edge I = A+2. "After edge k" means the clock cycle that follows rising edge k. A burst's *end edge* X is I+BL if nothing cuts it, or the registration edge of the command that cuts it.

Top module: `burst_intr_sched`

## Requirements
- R1: While rst_n is low, and after its release until the first command, data_valid, data_write, data_owner, dqm and precharge_start are all 0.
- R2: cmd_op encodes 00 idle, 01 ACTIVE, 10 READ, 11 WRITE. cfg_burst_code c selects a burst of 2^c beats (0..3 gives 1, 2, 4, 8). A WRITE registered at edge I reports data_valid=1, data_write=1, data_owner=bank after edges I to I+BL-1. Outside beats, data_write and data_owner read 0.
- R3: A READ registered at edge I reports data_valid=1, data_write=0, data_owner=bank after edges I+CL to I+CL+BL-1. CL is cfg_cas_lat, which takes the value 2 or 3.
- R4: A READ registered at edge J while another READ still has beats to deliver stops the old read's beats after edge J+CL-1. The new read's data starts after edge J+CL.
- R5: A WRITE registered at edge J while a READ still has beats to deliver takes over the bus at once: its beats start after edge J. While the two overlap, the write beat is the one reported.
- R6: For a WRITE that interrupts a READ (as in R5), dqm is 1 after edge J-1 only if the read had no auto-precharge. It is 1 after edges J-2 and J-1 if the read had auto-precharge. With no such interruption, dqm stays 0.
- R7: A READ or WRITE registered at edge J cuts a running WRITE so that the last beat of the old write is after edge J-1. An interrupting READ then delivers data from edge J+CL, and the bus is idle in between.
- R8: For a READ with auto-precharge, precharge_start[bank] is 1 for exactly one cycle, after its end edge X. This holds both when the read runs to completion and when it is interrupted.
- R9: For a WRITE with auto-precharge, precharge_start[bank] is 1 for one cycle after edge X+cfg_twr (cfg_twr from 1 to 15).
- R10: The interrupting command's own auto-precharge flag does not change how the interrupted burst ends. ACTIVE and idle commands never cut a burst and never produce beats.
- R11: Bursts issued without auto-precharge never pulse precharge_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command code, two clocks ahead of registration |
| cmd_bank | input | 2 | Target bank of the command |
| cmd_ap | input | 1 | Auto-precharge flag of the command |
| cfg_cas_lat | input | 2 | CAS latency, 2 or 3 |
| cfg_burst_code | input | 2 | Burst length code, length 2^code |
| cfg_twr | input | 4 | Write recovery in clocks |
| data_valid | output | 1 | A data beat is on the bus this cycle |
| data_write | output | 1 | The beat is write data |
| data_owner | output | 2 | Bank that drives or receives the beat |
| dqm | output | 1 | Data mask, asserted ahead of an interrupting WRITE |
| precharge_start | output | 4 | One-cycle pulse per bank when its auto-precharge begins |

## Verification
The hardest situation to reach is a WRITE to one bank that lands while a READ with auto-precharge in another bank still has beats queued. In that case the mask must rise two clocks before the write, read beats must be overridden mid-flight, and the precharge of the read's bank must start at the write's registration edge. The directed stimulus reaches it by issuing an eight-beat read and then a write four clocks later, with CAS latency 3. Some of the read's beats have then already reached the bus while others are still in the latency pipeline. Write-recovery precharge is reached by cutting a write with auto-precharge using a read that itself carries auto-precharge. Both banks' strobes then fall inside one window, at separately computed edges.

// File: rtl/bis_pkg.sv
package bis_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_ACT  = 2'b01,
      OP_RD   = 2'b10,
      OP_WR   = 2'b11
   } op_e;

   // Number of cycles between command acceptance and device registration.
   localparam int unsigned CMD_LEAD = 2;
endpackage

// File: rtl/bis_tracker.sv
module bis_tracker
   import bis_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int LEFT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  op_e               cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic              cmd_ap,
   input  logic [LEFT_W-1:0] len_m1,
   output logic              beat_vld,
   output logic              beat_wr,
   output logic [BANK_W-1:0] beat_bank,
   output logic              end_vld,
   output logic              end_wr,
   output logic              end_ap,
   output logic [BANK_W-1:0] end_bank,
   output logic              dqm
);
   logic              act_q;
   logic              cur_wr_q;
   logic              cur_ap_q;
   logic [BANK_W-1:0] cur_bank_q;
   logic [LEFT_W-1:0] left_q;
   logic              dqm_arm_q;
   logic              new_rw;
   logic              cut;
   logic              wr_cuts_rd;

   assign new_rw     = (cmd_op == OP_RD) || (cmd_op == OP_WR);
   assign cut        = act_q && (left_q != '0) && new_rw;
   assign wr_cuts_rd = cut && (cmd_op == OP_WR) && !cur_wr_q;

   // burst end: either all beats went out, or a new burst replaces it
   assign end_vld  = act_q && ((left_q == '0) || new_rw);
   assign end_wr   = cur_wr_q;
   assign end_ap   = cur_ap_q;
   assign end_bank = cur_bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         cur_wr_q   <= 1'b0;
         cur_ap_q   <= 1'b0;
         cur_bank_q <= '0;
         left_q     <= '0;
         beat_vld   <= 1'b0;
         beat_wr    <= 1'b0;
         beat_bank  <= '0;
      end else if (new_rw) begin
         act_q      <= 1'b1;
         cur_wr_q   <= (cmd_op == OP_WR);
         cur_ap_q   <= cmd_ap;
         cur_bank_q <= cmd_bank;
         left_q     <= len_m1;
         beat_vld   <= 1'b1;
         beat_wr    <= (cmd_op == OP_WR);
         beat_bank  <= cmd_bank;
      end else if (act_q && (left_q != '0)) begin
         left_q    <= left_q - 1'b1;
         beat_vld  <= 1'b1;
         beat_wr   <= cur_wr_q;
         beat_bank <= cur_bank_q;
      end else begin
         act_q     <= 1'b0;
         beat_vld  <= 1'b0;
         beat_wr   <= 1'b0;
         beat_bank <= '0;
      end
   end

   // mask lead: two clocks for an auto-precharge read, one clock otherwise
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dqm       <= 1'b0;
         dqm_arm_q <= 1'b0;
      end else begin
         dqm       <= (wr_cuts_rd && cur_ap_q) || dqm_arm_q;
         dqm_arm_q <= wr_cuts_rd;
      end
   end

   // R2
   beat_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      new_rw |=> (beat_vld && (beat_bank == $past(cmd_bank)) &&
                  (beat_wr == $past(cmd_op == OP_WR))));

   // R10
   act_no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_op == OP_ACT) && act_q && (left_q != '0)) |=>
         (beat_vld && (beat_bank == $past(cur_bank_q))));
endmodule

// File: rtl/bis_bank_pc.sv
module bis_bank_pc #(
   parameter int BANK_ID = 0,
   parameter int BANK_W  = 2,
   parameter int TWR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              end_vld,
   input  logic              end_wr,
   input  logic              end_ap,
   input  logic [BANK_W-1:0] end_bank,
   input  logic [TWR_W-1:0]  twr,
   output logic              pc_pulse
);
   logic [TWR_W-1:0] rec_q;
   logic [TWR_W-1:0] twr_eff;
   logic             hit;

   assign hit     = end_vld && end_ap && (end_bank == BANK_W'(BANK_ID));
   assign twr_eff = (twr == '0) ? TWR_W'(1) : twr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rec_q    <= '0;
         pc_pulse <= 1'b0;
      end else begin
         pc_pulse <= (hit && !end_wr) || (rec_q == TWR_W'(1));
         if (hit && end_wr)
            rec_q <= twr_eff;
         else if (rec_q != '0)
            rec_q <= rec_q - 1'b1;
      end
   end
endmodule

// File: rtl/bis_out_pipe.sv
module bis_out_pipe #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2,
   parameter int MAX_CL    = 3,
   parameter int LEAD      = 2,
   parameter int CL_W      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 beat_vld,
   input  logic                 beat_wr,
   input  logic [BANK_W-1:0]    beat_bank,
   input  logic [NUM_BANKS-1:0] pc_ahead,
   input  logic [CL_W-1:0]      cl_sel,
   output logic                 data_valid,
   output logic                 data_write,
   output logic [BANK_W-1:0]    data_owner,
   output logic [NUM_BANKS-1:0] precharge_start
);
   localparam int DEPTH = LEAD + MAX_CL;
   localparam int IDX_W = $clog2(DEPTH + 1);

   logic                 vld_d  [1:DEPTH];
   logic                 wr_d   [1:DEPTH];
   logic [BANK_W-1:0]    bank_d [1:DEPTH];
   logic [NUM_BANKS-1:0] pc_d   [1:LEAD];
   logic [IDX_W-1:0]     tap;
   logic                 wr_hit;
   logic                 rd_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 1; s <= DEPTH; s++) begin
            vld_d[s]  <= 1'b0;
            wr_d[s]   <= 1'b0;
            bank_d[s] <= '0;
         end
      end else begin
         vld_d[1]  <= beat_vld;
         wr_d[1]   <= beat_wr;
         bank_d[1] <= beat_bank;
         for (int s = 2; s <= DEPTH; s++) begin
            vld_d[s]  <= vld_d[s-1];
            wr_d[s]   <= wr_d[s-1];
            bank_d[s] <= bank_d[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 1; s <= LEAD; s++) pc_d[s] <= '0;
      end else begin
         pc_d[1] <= pc_ahead;
         for (int s = 2; s <= LEAD; s++) pc_d[s] <= pc_d[s-1];
      end
   end

   assign tap    = IDX_W'(LEAD) + IDX_W'(cl_sel);
   assign wr_hit = vld_d[LEAD] && wr_d[LEAD];
   assign rd_hit = vld_d[tap] && !wr_d[tap];

   always_comb begin
      data_valid = wr_hit || rd_hit;
      data_write = wr_hit;
      if (wr_hit)
         data_owner = bank_d[LEAD];
      else if (rd_hit)
         data_owner = bank_d[tap];
      else
         data_owner = '0;
   end

   assign precharge_start = pc_d[LEAD];
endmodule

// File: rtl/burst_intr_sched.sv
module burst_intr_sched
   import bis_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int MAX_BL_LOG2 = 3,
   parameter int MAX_CL      = 3,
   parameter int TWR_W       = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    cmd_op,
   input  logic [$clog2(NUM_BANKS)-1:0]  cmd_bank,
   input  logic                          cmd_ap,
   input  logic [$clog2(MAX_CL+1)-1:0]   cfg_cas_lat,
   input  logic [$clog2(MAX_BL_LOG2+1)-1:0] cfg_burst_code,
   input  logic [TWR_W-1:0]              cfg_twr,
   output logic                          data_valid,
   output logic                          data_write,
   output logic [$clog2(NUM_BANKS)-1:0]  data_owner,
   output logic                          dqm,
   output logic [NUM_BANKS-1:0]          precharge_start
);
   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int LEFT_W = (MAX_BL_LOG2 < 1) ? 1 : MAX_BL_LOG2;
   localparam int CL_W   = $clog2(MAX_CL + 1);
   localparam int BC_W   = $clog2(MAX_BL_LOG2 + 1);
   localparam int LEAD   = CMD_LEAD;

   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (MAX_CL < 2) begin : g_bad_cl
         $error("MAX_CL must be at least 2");
      end
      if (TWR_W < 1) begin : g_bad_twr
         $error("TWR_W must be at least 1");
      end
   endgenerate

   op_e                  op_c;
   logic [LEFT_W-1:0]    len_m1;
   logic [CL_W-1:0]      cl_eff;
   logic                 beat_vld, beat_wr;
   logic [BANK_W-1:0]    beat_bank;
   logic                 end_vld, end_wr, end_ap;
   logic [BANK_W-1:0]    end_bank;
   logic [NUM_BANKS-1:0] pc_ahead;

   assign op_c = op_e'(cmd_op);

   always_comb begin
      if (cfg_burst_code > BC_W'(MAX_BL_LOG2))
         len_m1 = {LEFT_W{1'b1}};
      else
         len_m1 = LEFT_W'((1 << cfg_burst_code) - 1);
   end

   always_comb begin
      if (cfg_cas_lat < CL_W'(2))
         cl_eff = CL_W'(2);
      else if (cfg_cas_lat > CL_W'(MAX_CL))
         cl_eff = CL_W'(MAX_CL);
      else
         cl_eff = cfg_cas_lat;
   end

   bis_tracker #(.BANK_W(BANK_W), .LEFT_W(LEFT_W)) u_trk (
      .clk(clk), .rst_n(rst_n),
      .cmd_op(op_c), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .len_m1(len_m1),
      .beat_vld(beat_vld), .beat_wr(beat_wr), .beat_bank(beat_bank),
      .end_vld(end_vld), .end_wr(end_wr), .end_ap(end_ap), .end_bank(end_bank),
      .dqm(dqm)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         bis_bank_pc #(.BANK_ID(b), .BANK_W(BANK_W), .TWR_W(TWR_W)) u_pc (
            .clk(clk), .rst_n(rst_n),
            .end_vld(end_vld), .end_wr(end_wr), .end_ap(end_ap),
            .end_bank(end_bank), .twr(cfg_twr), .pc_pulse(pc_ahead[b])
         );
      end
   endgenerate

   bis_out_pipe #(
      .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .MAX_CL(MAX_CL),
      .LEAD(LEAD), .CL_W(CL_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n),
      .beat_vld(beat_vld), .beat_wr(beat_wr), .beat_bank(beat_bank),
      .pc_ahead(pc_ahead), .cl_sel(cl_eff),
      .data_valid(data_valid), .data_write(data_write),
      .data_owner(data_owner), .precharge_start(precharge_start)
   );

   // R6
   dqm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dqm) |-> (data_valid && data_write));

   // R8
   rd_ap_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_vld && end_ap && !end_wr) |=> pc_ahead[$past(end_bank)]);
endmodule

// File: tb/tb_burst_intr_sched.sv
module tb_burst_intr_sched;
   localparam int WIN = 28;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [1:0] cmd_bank = 2'b00;
   logic       cmd_ap = 1'b0;
   logic [1:0] cfg_cas_lat = 2'd2;
   logic [1:0] cfg_burst_code = 2'd3;
   logic [3:0] cfg_twr = 4'd2;
   logic       data_valid, data_write, dqm;
   logic [1:0] data_owner;
   logic [3:0] precharge_start;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic       e_v [WIN];
   logic       e_w [WIN];
   logic [1:0] e_o [WIN];
   logic       e_m [WIN];
   logic [3:0] e_p [WIN];
   logic [1:0] p_op [WIN];
   logic [1:0] p_bk [WIN];
   logic       p_ap [WIN];

   always #10 clk = ~clk;

   burst_intr_sched dut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .cmd_ap(cmd_ap), .cfg_cas_lat(cfg_cas_lat),
      .cfg_burst_code(cfg_burst_code), .cfg_twr(cfg_twr),
      .data_valid(data_valid), .data_write(data_write),
      .data_owner(data_owner), .dqm(dqm), .precharge_start(precharge_start)
   );

   task automatic clear_plan();
      for (int k = 0; k < WIN; k++) begin
         e_v[k] = 0; e_w[k] = 0; e_o[k] = 0; e_m[k] = 0; e_p[k] = 0;
         p_op[k] = 0; p_bk[k] = 0; p_ap[k] = 0;
      end
   endtask

   task automatic cmd(input int a, input logic [1:0] op, input int bank, input logic ap);
      p_op[a] = op; p_bk[a] = 2'(bank); p_ap[a] = ap;
   endtask

   // read accepted at a: registered a+2, beats CL later
   task automatic rd_beats(input int a, input int n, input int bank, input int cl);
      for (int j = 0; j < n; j++) begin
         e_v[a+2+cl+j] = 1; e_w[a+2+cl+j] = 0; e_o[a+2+cl+j] = 2'(bank);
      end
   endtask

   task automatic wr_beats(input int a, input int n, input int bank);
      for (int j = 0; j < n; j++) begin
         e_v[a+2+j] = 1; e_w[a+2+j] = 1; e_o[a+2+j] = 2'(bank);
      end
   endtask

   task automatic chk(input string tag, input int k, input logic [8:0] act, input logic [8:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: got v/w/own/dqm/pc=%b expected %b", tag, k, act, exp);
      end
   endtask

   task automatic run(input string tag, input int cas, input int bcode, input int twr);
      @(negedge clk);
      cfg_cas_lat = 2'(cas); cfg_burst_code = 2'(bcode); cfg_twr = 4'(twr);
      rst_n = 0; cmd_op = 0; cmd_bank = 0; cmd_ap = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      for (int k = 0; k < WIN; k++) begin
         cmd_op = p_op[k]; cmd_bank = p_bk[k]; cmd_ap = p_ap[k];
         @(posedge clk);
         @(negedge clk);
         chk(tag, k, {data_valid, data_write, data_owner, dqm, precharge_start},
             {e_v[k], e_w[k], e_o[k], e_m[k], e_p[k]});
      end
      cmd_op = 0;
   endtask

   // R1: outputs idle during reset, even with a command on the port
   task automatic t_reset();
      @(negedge clk);
      rst_n = 0; cmd_op = 2'b11; cmd_bank = 2'd1; cmd_ap = 1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R1", k, {data_valid, data_write, data_owner, dqm, precharge_start}, 9'd0);
      end
      cmd_op = 0; cmd_ap = 0;
      clear_plan();
      run("R1", 2, 2, 2);
   endtask

   task automatic t_write_plain();
      clear_plan(); cmd(0, 2'b11, 1, 0); wr_beats(0, 4, 1);
      run("R2/R11", 2, 2, 2);
   endtask

   task automatic t_read_plain();
      clear_plan(); cmd(0, 2'b10, 2, 0); rd_beats(0, 8, 2, 3);
      run("R3", 3, 3, 2);
      clear_plan(); cmd(0, 2'b10, 3, 0); rd_beats(0, 1, 3, 2);
      run("R3", 2, 0, 2);
   endtask

   task automatic t_read_read();
      clear_plan(); cmd(0, 2'b10, 0, 0); cmd(3, 2'b10, 3, 0);
      rd_beats(0, 3, 0, 2); rd_beats(3, 8, 3, 2);
      run("R4", 2, 3, 2);
   endtask

   task automatic t_write_cuts_read();
      clear_plan(); cmd(0, 2'b10, 0, 0); cmd(4, 2'b11, 1, 0);
      rd_beats(0, 4, 0, 3); wr_beats(4, 8, 1);
      e_m[5] = 1;
      run("R5/R6", 3, 3, 2);
   endtask

   task automatic t_write_cuts_read_ap();
      clear_plan(); cmd(0, 2'b10, 2, 1); cmd(4, 2'b11, 0, 0);
      rd_beats(0, 4, 2, 3); wr_beats(4, 8, 0);
      e_m[4] = 1; e_m[5] = 1; e_p[6][2] = 1;
      run("R6/R8", 3, 3, 2);
   endtask

   task automatic t_read_cuts_write_ap();
      clear_plan(); cmd(0, 2'b11, 3, 1); cmd(3, 2'b10, 1, 1);
      wr_beats(0, 3, 3); rd_beats(3, 8, 1, 2);
      e_p[8][3] = 1;   // cut at edge 5, recovery 3
      e_p[13][1] = 1;  // registered 5, eight beats
      run("R7/R9/R10", 2, 3, 3);
   endtask

   task automatic t_read_ap_full();
      clear_plan(); cmd(0, 2'b10, 0, 1); cmd(1, 2'b01, 1, 0); cmd(2, 2'b01, 2, 1);
      rd_beats(0, 4, 0, 2); e_p[6][0] = 1;
      run("R8/R10", 2, 2, 2);
   endtask

   task automatic t_write_ap_full();
      clear_plan(); cmd(0, 2'b11, 2, 1); wr_beats(0, 2, 2); e_p[6][2] = 1;
      run("R9", 2, 1, 2);
   endtask

   task automatic t_write_write();
      clear_plan(); cmd(0, 2'b11, 0, 0); cmd(2, 2'b11, 1, 1);
      wr_beats(0, 2, 0); wr_beats(2, 8, 1); e_p[13][1] = 1;
      run("R7/R9/R11", 3, 3, 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_write_plain();
      t_read_plain();
      t_read_read();
      t_write_cuts_read();
      t_write_cuts_read_ap();
      t_read_cuts_write_ap();
      t_read_ap_full();
      t_write_ap_full();
      t_write_write();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule